// File: doc/BRIEF.md
# SDRAM Precharge Timing Scheduler

This block sits beside an SDRAM command issuer and watches every command that goes to the memory. For each bank it works out the first cycle at which a precharge becomes legal after a read or write burst. For reads the limit is set by how far the precharge may lead the final data beat, which depends on CAS latency. For writes it adds write recovery after the final data beat. The issuer reads one "precharge allowed" bit per bank and never needs its own burst counters.

A read or write issued with A10 high asks the memory to close the row by itself. The scheduler then follows the bank through the rest of its burst and through the internal precharge and its row-precharge time (tRP). It reports the bank as busy for that whole span and pulses a done bit when the bank is usable again. It also raises a one-cycle error flag when the command stream breaks the rules: a precharge that comes too early, a new access to a bank still closing itself, or a burst stop while any bank is closing itself.

Burst length and CAS latency are inputs sampled with each command, so mode changes take effect per command. Write recovery (TWR, in clocks, at least 1) and row-precharge time (TRP, in clocks, at least 1) are parameters.

Top module: `sdram_pre_sched`

## Requirements
- R1: Commands are decoded only while csN is low. READ is rasN=1 casN=0 weN=1. WRITE is rasN=1 casN=0 weN=0. PRECHARGE is rasN=0 casN=1 weN=0. BURST STOP is rasN=1 casN=1 weN=0. Any other pattern, or csN high, has no effect on any output.
- R2: After reset, every bit of preOk is 1, every bit of apBusy and apDone is 0, and cmdErr is 0.
- R3: Suppose a legal READ with a10=0 to bank b is issued in cycle t. Burst length is taken from blCode (0,1,2,3 give 1,2,4,8) and casLat3=1 selects CAS latency 3, otherwise 2. Then preOk[b] is 0 in cycles t+1 to t+BL-1 and 1 from t+BL. This is one clock (CL 2) or two clocks (CL 3) before the last data out at t+CL+BL-1.
- R4: Suppose a legal WRITE with a10=0 to bank b is issued in cycle t. The last data in is at t+BL-1. Then preOk[b] is 0 in cycles t+1 to t+BL+TWR-2 and 1 from t+BL+TWR-1.
- R5: A legal READ or WRITE to a bank restarts that bank's timing from the new command, whatever remained of the earlier one.
- R6: A legal READ or WRITE with a10=1 starts auto-precharge. The internal precharge starts in cycle s, which is the cycle R3 or R4 gives for preOk. apBusy[b] is 1 and preOk[b] is 0 from t+1 to s+TRP-1.
- R7: apDone[b] is 1 for exactly cycle s+TRP. From that cycle on, apBusy[b] is 0 and preOk[b] is 1.
- R8: A PRECHARGE with a10=0 to a bank whose preOk is 0 raises cmdErr in the next cycle. So does a PRECHARGE with a10=1 while any preOk bit is 0.
- R9: A READ or WRITE to a bank whose apBusy is 1 raises cmdErr in the next cycle. So does a BURST STOP while any apBusy bit is 1. An access to a different bank is legal.
- R10: cmdErr is high for one cycle per illegal command. An illegal command, or a legal PRECHARGE, leaves every bank's timing unchanged.
- R11: A command to one bank never changes the outputs of another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select of the observed command, active low |
| rasN | input | 1 | Row strobe of the observed command, active low |
| casN | input | 1 | Column strobe of the observed command, active low |
| weN | input | 1 | Write enable of the observed command, active low |
| bankAddr | input | BANK_W | Bank address of the command |
| a10 | input | 1 | Auto-precharge on READ/WRITE; all-banks on PRECHARGE |
| blCode | input | 2 | Burst length code: 0=1, 1=2, 2=4, 3=8 |
| casLat3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| preOk | output | 2**BANK_W | Per bank: a precharge is legal in this cycle |
| apBusy | output | 2**BANK_W | Per bank: auto-precharge burst or tRP still running |
| apDone | output | 2**BANK_W | Per bank: one-cycle pulse when auto-precharge finishes |
| cmdErr | output | 1 | One-cycle pulse after an illegal command |

## Verification
The hardest situation to reach is a command that lands exactly on an edge cycle of auto-precharge. Examples are a new access in the apDone cycle, a precharge in the last busy cycle, or a second burst that reloads a bank whose first burst has not ended. Directed sequences place such commands at offsets computed from burst length, TWR and TRP. A long random run then mixes commands across banks with dense traffic, and a cycle-accurate model checks every output bit in every cycle, so those edges also come up with many other combinations around them.

// File: rtl/sdram_pre_pkg.sv
package sdram_pre_pkg;

  parameter int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int MAX_BL    = 8;
  localparam int BLC_W     = 2;

  typedef enum logic [1:0] {
    BK_IDLE     = 2'd0,
    BK_AP_BURST = 2'd1,
    BK_AP_RECOV = 2'd2
  } bank_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 load;
    logic                 isWrite;
    logic                 isAuto;
    logic [NUM_BANKS-1:0] bankHit;
    logic [BLC_W-1:0]     blCode;
    logic                 casLat3;
  } strobe_t;

endpackage

// File: rtl/sdram_pre_ctrl.sv
module sdram_pre_ctrl
  import sdram_pre_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic                 a10,
  input  logic [BLC_W-1:0]     blCode,
  input  logic                 casLat3,
  input  logic [NUM_BANKS-1:0] preOk,
  input  logic [NUM_BANKS-1:0] apBusy,
  output strobe_t              strb,
  output logic                 cmdErr
);

  logic isRead, isWrite, isPre, isBst;
  logic [NUM_BANKS-1:0] bankHit;
  logic busyHit, notReadyHit;
  logic preIllegal, rwIllegal, bstIllegal, illegal;

  // command decode
  always_comb begin
    isRead  = !csN &&  rasN && !casN &&  weN;
    isWrite = !csN &&  rasN && !casN && !weN;
    isPre   = !csN && !rasN &&  casN && !weN;
    isBst   = !csN &&  rasN &&  casN && !weN;
  end

  assign bankHit = NUM_BANKS'(1) << bankAddr;

  // legality against the current per-bank state
  always_comb begin
    busyHit     = |(apBusy & bankHit);
    notReadyHit = |(~preOk & bankHit);
    preIllegal  = isPre && (a10 ? !(&preOk) : notReadyHit);
    rwIllegal   = (isRead || isWrite) && busyHit;
    bstIllegal  = isBst && (|apBusy);
    illegal     = preIllegal || rwIllegal || bstIllegal;
  end

  always_comb begin
    strb.load    = (isRead || isWrite) && !rwIllegal;
    strb.isWrite = isWrite;
    strb.isAuto  = a10;
    strb.bankHit = bankHit;
    strb.blCode  = blCode;
    strb.casLat3 = casLat3;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdErr <= 1'b0;
    else       cmdErr <= illegal;
  end

endmodule

// File: rtl/sdram_pre_datapath.sv
module sdram_pre_datapath
  import sdram_pre_pkg::*;
#(
  parameter int TWR = 2,
  parameter int TRP = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  output logic [NUM_BANKS-1:0] preOk,
  output logic [NUM_BANKS-1:0] apBusy,
  output logic [NUM_BANKS-1:0] apDone
);

  localparam int CNT_W = $clog2(MAX_BL + TWR + TRP + 4);

  logic [CNT_W-1:0] burstLen, clCycles, readLead, lastBeat, loadVal;

  // wait count measured from the final data beat
  always_comb begin
    burstLen = CNT_W'(1) << strb.blCode;
    clCycles = strb.casLat3 ? CNT_W'(3) : CNT_W'(2);
    readLead = clCycles - CNT_W'(1);
    if (strb.isWrite) begin
      lastBeat = burstLen - CNT_W'(1);
      loadVal  = lastBeat + CNT_W'(TWR) - CNT_W'(1);
    end else begin
      lastBeat = clCycles + burstLen - CNT_W'(1);
      loadVal  = lastBeat - readLead - CNT_W'(1);
    end
  end

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    bank_state_e      bankSt;
    logic [CNT_W-1:0] bankCnt;
    logic             cntZero;

    assign cntZero = (bankCnt == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankSt  <= BK_IDLE;
        bankCnt <= '0;
      end else if (strb.load && strb.bankHit[gb]) begin
        bankCnt <= loadVal;
        bankSt  <= strb.isAuto ? BK_AP_BURST : BK_IDLE;
      end else begin
        unique case (bankSt)
          BK_IDLE: begin
            if (!cntZero) bankCnt <= bankCnt - CNT_W'(1);
          end
          BK_AP_BURST: begin
            if (cntZero) begin
              bankSt  <= BK_AP_RECOV;
              bankCnt <= CNT_W'(TRP - 1);
            end else begin
              bankCnt <= bankCnt - CNT_W'(1);
            end
          end
          BK_AP_RECOV: begin
            if (cntZero) bankSt  <= BK_IDLE;
            else         bankCnt <= bankCnt - CNT_W'(1);
          end
          default: begin
            bankSt  <= BK_IDLE;
            bankCnt <= '0;
          end
        endcase
      end
    end

    always_comb begin
      apDone[gb] = (bankSt == BK_AP_RECOV) && cntZero;
      apBusy[gb] = (bankSt == BK_AP_BURST) ||
                   ((bankSt == BK_AP_RECOV) && !cntZero);
      preOk[gb]  = ((bankSt == BK_IDLE) && cntZero) || apDone[gb];
    end
  end

endmodule

// File: rtl/sdram_pre_sched.sv
module sdram_pre_sched
  import sdram_pre_pkg::*;
#(
  parameter int TWR = 2,
  parameter int TRP = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic                 a10,
  input  logic [BLC_W-1:0]     blCode,
  input  logic                 casLat3,
  output logic [NUM_BANKS-1:0] preOk,
  output logic [NUM_BANKS-1:0] apBusy,
  output logic [NUM_BANKS-1:0] apDone,
  output logic                 cmdErr
);

  strobe_t strb;

  sdram_pre_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .bankAddr (bankAddr),
    .a10      (a10),
    .blCode   (blCode),
    .casLat3  (casLat3),
    .preOk    (preOk),
    .apBusy   (apBusy),
    .strb     (strb),
    .cmdErr   (cmdErr)
  );

  sdram_pre_datapath #(.TWR(TWR), .TRP(TRP)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .preOk  (preOk),
    .apBusy (apBusy),
    .apDone (apDone)
  );

endmodule

// File: rtl/sdram_pre_sched_chk.sv
module sdram_pre_sched_chk
  import sdram_pre_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 rasN,
  input logic                 casN,
  input logic                 weN,
  input logic [BANK_W-1:0]    bankAddr,
  input logic                 a10,
  input logic [BLC_W-1:0]     blCode,
  input logic [NUM_BANKS-1:0] preOk,
  input logic [NUM_BANKS-1:0] apBusy,
  input logic [NUM_BANKS-1:0] apDone,
  input logic                 cmdErr
);

  p_no_err_deselect_r1: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !cmdErr);

  p_pre_early_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && !weN && !a10 && !preOk[bankAddr]) |=> cmdErr);

  p_pre_all_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && !weN && a10 && !(&preOk)) |=> cmdErr);

  p_rw_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rasN && !casN && apBusy[bankAddr]) |=> cmdErr);

  p_bst_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rasN && casN && !weN && (|apBusy)) |=> cmdErr);

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_chk
    p_busy_blocks_pre_r6: assert property (@(posedge clk) disable iff (!rstN)
      !(apBusy[gb] && preOk[gb]));

    p_ap_start_r6: assert property (@(posedge clk) disable iff (!rstN)
      (!csN && rasN && !casN && a10 && bankAddr == BANK_W'(gb) && !apBusy[gb])
      |=> apBusy[gb]);

    p_done_release_r7: assert property (@(posedge clk) disable iff (!rstN)
      (apDone[gb] && !(!csN && rasN && !casN && bankAddr == BANK_W'(gb)))
      |=> (preOk[gb] && !apBusy[gb] && !apDone[gb]));

    p_read_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
      (!csN && rasN && !casN && weN && bankAddr == BANK_W'(gb) &&
       !apBusy[gb] && blCode != 2'd0) |=> !preOk[gb]);
  end

endmodule

bind sdram_pre_sched sdram_pre_sched_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .bankAddr (bankAddr),
  .a10      (a10),
  .blCode   (blCode),
  .preOk    (preOk),
  .apBusy   (apBusy),
  .apDone   (apDone),
  .cmdErr   (cmdErr)
);

// File: tb/sdram_pre_sched_tb_top.sv
`timescale 1ns/1ps
module sdram_pre_sched_tb_top;
  import sdram_pre_pkg::*;

  localparam int TWR = 2;
  localparam int TRP = 3;
  localparam int NB  = NUM_BANKS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [BANK_W-1:0] bankAddr = '0;
  logic a10 = 1'b0;
  logic [BLC_W-1:0] blCode = '0;
  logic casLat3 = 1'b0;
  logic [NB-1:0] preOk, apBusy, apDone;
  logic cmdErr;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int readyAt [NB];
  bit apMode  [NB];
  bit expErr  = 1'b0;

  always #2 clk = ~clk;

  sdram_pre_sched #(.TWR(TWR), .TRP(TRP)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .a10(a10), .blCode(blCode), .casLat3(casLat3),
    .preOk(preOk), .apBusy(apBusy), .apDone(apDone), .cmdErr(cmdErr)
  );

  // reference: outputs of bank b in cycle c
  function automatic void expBank(input int b, input int c,
                                  output bit ok, output bit busy, output bit done);
    int idleAt;
    if (!apMode[b]) begin
      ok = (c >= readyAt[b]); busy = 1'b0; done = 1'b0;
    end else begin
      idleAt = readyAt[b] + TRP;
      if (c < idleAt)       begin ok = 1'b0; busy = 1'b1; done = 1'b0; end
      else if (c == idleAt) begin ok = 1'b1; busy = 1'b0; done = 1'b1; end
      else                  begin ok = 1'b1; busy = 1'b0; done = 1'b0; end
    end
  endfunction

  function automatic int readWait(input int blc);
    return (1 << blc);
  endfunction

  function automatic int writeWait(input int blc);
    return (1 << blc) + TWR - 1;
  endfunction

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s got %b exp %b at cycle %0d", tag, what, got, exp, cyc);
    end
  endtask

  task automatic step(input string tag, input bit cs, input bit ras, input bit cas,
                      input bit we, input int ba, input bit a10v, input int blc,
                      input bit cl3);
    logic [NB-1:0] eOk, eBusy, eDone;
    bit ok, busy, done, isRw, isPre, isBst, illegal;
    @(negedge clk);
    cyc++;
    for (int b = 0; b < NB; b++) begin
      expBank(b, cyc, ok, busy, done);
      eOk[b] = ok; eBusy[b] = busy; eDone[b] = done;
    end
    cmp(tag, "preOk", int'(preOk), int'(eOk));
    cmp(tag, "apBusy", int'(apBusy), int'(eBusy));
    cmp(tag, "apDone", int'(apDone), int'(eDone));
    cmp(tag, "cmdErr", int'(cmdErr), int'(expErr));
    isRw  = !cs && ras && !cas;
    isPre = !cs && !ras && cas && !we;
    isBst = !cs && ras && cas && !we;
    illegal = (isRw && eBusy[ba]) ||
              (isPre && (a10v ? (eOk != '1) : !eOk[ba])) ||
              (isBst && (eBusy != '0));
    expErr = illegal;
    if (isRw && !illegal) begin
      readyAt[ba] = cyc + (we ? readWait(blc) : writeWait(blc));
      apMode[ba]  = a10v;
    end
    csN = cs; rasN = ras; casN = cas; weN = we;
    bankAddr = BANK_W'(ba); a10 = a10v; blCode = BLC_W'(blc); casLat3 = cl3;
  endtask

  task automatic nop(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0, 0, 1'b0);
  endtask
  task automatic rd(input string tag, input int b, input bit ap, input int blc, input bit cl3);
    step(tag, 1'b0, 1'b1, 1'b0, 1'b1, b, ap, blc, cl3);
  endtask
  task automatic wr(input string tag, input int b, input bit ap, input int blc);
    step(tag, 1'b0, 1'b1, 1'b0, 1'b0, b, ap, blc, 1'b0);
  endtask
  task automatic pre(input string tag, input int b, input bit all);
    step(tag, 1'b0, 1'b0, 1'b1, 1'b0, b, all, 0, 1'b0);
  endtask
  task automatic bst(input string tag);
    step(tag, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0, 0, 1'b0);
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int r;
    for (int b = 0; b < NB; b++) begin readyAt[b] = 0; apMode[b] = 1'b0; end
    void'($urandom(32'd777));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: reset values
    cmp("R2 reset", "preOk", int'(preOk), (1 << NB) - 1);
    cmp("R2 reset", "apBusy", int'(apBusy), 0);
    cmp("R2 reset", "apDone", int'(apDone), 0);
    cmp("R2 reset", "cmdErr", int'(cmdErr), 0);

    // R3: read timing, both latencies, all lengths
    for (int blc = 0; blc < 4; blc++) begin
      rd("R3 read CL2", 0, 1'b0, blc, 1'b0); nop("R3 read CL2", 9);
      rd("R3 read CL3", 1, 1'b0, blc, 1'b1); nop("R3 read CL3", 9);
    end
    // R4: write recovery
    for (int blc = 0; blc < 4; blc++) begin
      wr("R4 write", 2, 1'b0, blc); nop("R4 write", 11);
    end
    // R8: early precharge, then legal one at the boundary
    rd("R8 early pre", 0, 1'b0, 2, 1'b0);
    pre("R8 early pre", 0, 1'b0);
    nop("R8 early pre", 2);
    pre("R8 boundary pre", 0, 1'b0);
    nop("R10 after pre", 3);
    wr("R8 pre all", 3, 1'b0, 3);
    pre("R8 pre all", 1, 1'b1);
    nop("R8 pre all", 10);
    pre("R8 pre all ok", 1, 1'b1);
    nop("R8 pre all ok", 2);
    // R5: reload mid-burst
    rd("R5 reload", 1, 1'b0, 3, 1'b0); nop("R5 reload", 3);
    wr("R5 reload", 1, 1'b0, 2); nop("R5 reload", 2);
    rd("R5 reload", 1, 1'b0, 0, 1'b1); nop("R5 reload", 8);
    // R6/R7: auto-precharge read and write
    rd("R6 auto read", 2, 1'b1, 2, 1'b1); nop("R7 auto done", 10);
    wr("R6 auto write", 3, 1'b1, 3); nop("R7 auto done", 16);
    // R9/R10/R11: interruptions of an auto burst
    rd("R9 auto base", 0, 1'b1, 3, 1'b0);
    rd("R11 other bank", 1, 1'b0, 1, 1'b0);
    rd("R9 same bank", 0, 1'b0, 0, 1'b0);
    bst("R9 burst stop");
    pre("R9 pre in auto", 0, 1'b0);
    wr("R9 write same bank", 0, 1'b0, 0);
    nop("R10 ignored", 12);
    // R7: new access exactly in the done cycle
    wr("R7 edge", 3, 1'b1, 0);
    nop("R7 edge", TWR - 1 + TRP);
    rd("R7 access on done", 3, 1'b1, 1, 1'b0);
    nop("R7 edge", 10);
    // R1: non-decoded patterns and deselect
    rd("R1 setup", 2, 1'b1, 3, 1'b0);
    step("R1 deselect", 1'b1, 1'b1, 1'b0, 1'b1, 2, 1'b0, 0, 1'b0);
    step("R1 deselect pre", 1'b1, 1'b0, 1'b1, 1'b0, 2, 1'b0, 0, 1'b0);
    step("R1 activate", 1'b0, 1'b0, 1'b1, 1'b1, 2, 1'b0, 0, 1'b0);
    step("R1 refresh pattern", 1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b0, 0, 1'b0);
    step("R1 mode pattern", 1'b0, 1'b0, 1'b0, 1'b0, 2, 1'b0, 0, 1'b0);
    nop("R1 after", 14);

    // R11: random traffic across banks
    for (int i = 0; i < 3000; i++) begin
      r = int'($urandom % 16);
      if (r < 5) nop("R11 random", 1);
      else if (r == 5) step("R1 random act", 1'b0, 1'b0, 1'b1, 1'b1,
                            int'($urandom % NB), 1'b0, 0, 1'b0);
      else if (r == 6) step("R1 random desel", 1'b1, 1'($urandom), 1'($urandom),
                            1'($urandom), int'($urandom % NB), 1'b0, 0, 1'b0);
      else if (r < 10) rd("R11 random rd", int'($urandom % NB), ($urandom % 4) == 0,
                          int'($urandom % 4), 1'($urandom));
      else if (r < 13) wr("R11 random wr", int'($urandom % NB), ($urandom % 4) == 0,
                          int'($urandom % 4));
      else if (r < 15) pre("R8 random pre", int'($urandom % NB), ($urandom % 4) == 0);
      else bst("R9 random bst");
    end
    nop("R11 drain", 20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule